// File: doc/BRIEF.md
# Accumulator-Machine Fetch and Address Sequencer

This block is the control sequencer at the front of a 16-bit accumulator machine with 12-bit word addresses. A four-bit sequence counter is decoded into one-hot timing steps. The block steps through four phases for every instruction. It copies the program counter into the address register and reads the addressed word into the instruction register. It then decodes the opcode field and the mode bit into an instruction class. For memory-reference words with the mode bit set, it makes one extra memory read that swaps the address register for a pointer. It then clears the counter so that the next instruction starts at the first step.

A word memory model of 4096 x 16 sits inside the block. Its write port is used only to place a program before the sequencer is started. The control side has an enumerated phase machine with four states. Fetch-address (T0) goes to Fetch-word (T1), then to Decode (T2), then to Resolve (T3), and Resolve goes back to Fetch-address. Each transition is taken only on a clock where `run` is high. When `run` is low, the machine stays in its current state. Synchronous reset forces the Fetch-address state. The phase machine drives the load, increment and clear strobes, the memory read strobe and a 3-bit bus source select. All registers take their new value from one shared internal bus.

Top module: `fetch_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows PC, SC, AR, IR and the latched mode bit all at zero. With `run` low, every strobe is low and `bus_sel` is 0.
- R2: In T0 (SC=0) with `run` high, `bus_sel`=2 (PC) and `ld_ar` and `inc_sc` are high. At the next edge AR takes the value of PC and SC becomes 1.
- R3: In T1, `bus_sel`=7 (memory) and `rd_mem`, `ld_ir`, `inc_pc` and `inc_sc` are high. At the next edge IR takes memory[AR] and PC increases by one.
- R4: In T2, `bus_sel`=5 (IR) and `ld_ar`, `latch_i` and `inc_sc` are high. At the next edge AR takes IR[11:0] and the mode bit takes IR[15].
- R5: The class comes from IR[14:12] and IR[15]. An opcode other than 7 is memory-reference. Opcode 7 with IR[15]=0 is register-reference. Opcode 7 with IR[15]=1 is input-output. Exactly one class flag is high.
- R6: `tstep` is one-hot with bit SC set, and SC always equals the index of the phase state (T0..T3). `opdec` is one-hot with bit IR[14:12] set.
- R7: In T3, a memory-reference word with the mode bit at 1 gives `bus_sel`=7 and raises `rd_mem` and `ld_ar`. AR then takes memory[AR][11:0].
- R8: In T3 of any other word (direct memory-reference, register-reference, input-output), `bus_sel`=0, `rd_mem` and `ld_ar` are low, and AR keeps its value.
- R9: T3 raises `clr_sc`, so SC is 0 on the next cycle. PC does not change there, so the next fetch uses the incremented PC.
- R10: While `run` is low, SC, PC, AR, IR and the mode bit hold and all strobes are low. Raising `run` again resumes at the same step.
- R11: A write through `load_we`/`load_addr`/`load_data` stores a word, and a later fetch of that address returns it.
- R12: PC is 12 bits wide and wraps from 4095 to 0 when it increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Start flag; the sequence advances one step per clock while high |
| load_we | input | 1 | Memory model write enable for program loading |
| load_addr | input | 12 | Memory model write address |
| load_data | input | 16 | Memory model write data |
| pc | output | 12 | Program counter |
| ar | output | 12 | Address register |
| ir | output | 16 | Instruction register |
| ind_mode | output | 1 | Latched addressing-mode bit |
| sc | output | 4 | Sequence counter |
| tstep | output | 16 | One-hot timing steps decoded from SC |
| opdec | output | 8 | One-hot opcode decode of IR[14:12] |
| is_memref | output | 1 | Memory-reference class flag |
| is_regref | output | 1 | Register-reference class flag |
| is_io | output | 1 | Input-output class flag |
| bus_sel | output | 3 | Bus source select: 0 none, 1 AR, 2 PC, 5 IR, 7 memory |
| ld_ar | output | 1 | Address register load strobe |
| ld_ir | output | 1 | Instruction register load strobe |
| inc_pc | output | 1 | Program counter increment strobe |
| rd_mem | output | 1 | Memory read strobe |
| latch_i | output | 1 | Mode-bit capture strobe |
| inc_sc | output | 1 | Sequence counter increment strobe |
| clr_sc | output | 1 | Sequence counter clear strobe |

## Verification
The assertions check three things on every cycle. The counter must follow the phase state. Each step must make the correct register transfer: PC into AR, memory into IR with PC+1, IR field into AR, and the pointer into AR only for indirect memory-reference words. Nothing may move while `run` is low. Some behaviour can only be shown by the bench scenarios. These are the exact strobe pattern and bus code in each step and the class and one-hot opcode for chosen instruction words. Others are the routing of an input-output word with its mode bit set past the indirect read, resuming after a stall in the middle of an instruction, and PC wrapping after a full pass through memory.

// File: rtl/sqc_pkg.sv
`timescale 1ns/1ps
package sqc_pkg;

    // Bus source codes; a neighbour bus multiplexer decodes these values.
    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_AR   = 3'd1,
        BUS_PC   = 3'd2,
        BUS_DR   = 3'd3,
        BUS_AC   = 3'd4,
        BUS_IR   = 3'd5,
        BUS_TR   = 3'd6,
        BUS_MEM  = 3'd7
    } bus_src_e;

    // Phase of the fetch/address sequence; the encoding equals the SC value.
    typedef enum logic [1:0] {
        PH_FETCH_ADDR = 2'd0,
        PH_FETCH_WORD = 2'd1,
        PH_DECODE     = 2'd2,
        PH_RESOLVE    = 2'd3
    } phase_e;

endpackage

// File: rtl/sqc_decoder.sv
`timescale 1ns/1ps
module sqc_decoder #(
    parameter int IN_W = 3
) (
    input  logic [IN_W-1:0]       code,
    output logic [(1<<IN_W)-1:0]  hot
);
    localparam int OUTS = 1 << IN_W;

    for (genvar k = 0; k < OUTS; k++) begin : g_line
        assign hot[k] = (code == IN_W'(k));
    end

endmodule

// File: rtl/sqc_seq_counter.sv
`timescale 1ns/1ps
module sqc_seq_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/sqc_word_mem.sv
`timescale 1ns/1ps
module sqc_word_mem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/sqc_datapath.sv
`timescale 1ns/1ps
module sqc_datapath
    import sqc_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_src_e      bus_sel,
    input  logic [DW-1:0] mem_q,
    input  logic          ld_ar,
    input  logic          ld_ir,
    input  logic          inc_pc,
    input  logic          latch_i,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] ar,
    output logic [DW-1:0] ir,
    output logic          ind_mode
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam int            PAD = DW - AW;

    logic [DW-1:0] bus;

    // Shared bus: one source at a time, chosen by the sequencer.
    always_comb begin
        unique case (bus_sel)
            BUS_AR:  bus = {{PAD{1'b0}}, ar};
            BUS_PC:  bus = {{PAD{1'b0}}, pc};
            BUS_IR:  bus = ir;
            BUS_MEM: bus = mem_q;
            default: bus = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            ar       <= '0;
            ir       <= '0;
            ind_mode <= 1'b0;
        end else begin
            if (inc_pc)  pc       <= pc + ONE;
            if (ld_ar)   ar       <= bus[AW-1:0];
            if (ld_ir)   ir       <= bus;
            if (latch_i) ind_mode <= bus[DW-1];
        end
    end

endmodule

// File: rtl/sqc_ctrl.sv
`timescale 1ns/1ps
module sqc_ctrl
    import sqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     is_memref,
    input  logic     ind_mode,
    output phase_e   phase,
    output bus_src_e bus_sel,
    output logic     ld_ar,
    output logic     ld_ir,
    output logic     inc_pc,
    output logic     rd_mem,
    output logic     latch_i,
    output logic     inc_sc,
    output logic     clr_sc
);
    phase_e state_q;
    phase_e state_d;

    // Next-state: one step per clock while run is high, hold otherwise.
    always_comb begin
        state_d = state_q;
        if (run) begin
            unique case (state_q)
                PH_FETCH_ADDR: state_d = PH_FETCH_WORD;
                PH_FETCH_WORD: state_d = PH_DECODE;
                PH_DECODE:     state_d = PH_RESOLVE;
                PH_RESOLVE:    state_d = PH_FETCH_ADDR;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_FETCH_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    // Strobes for the current state.
    always_comb begin
        bus_sel = BUS_NONE;
        ld_ar   = 1'b0;
        ld_ir   = 1'b0;
        inc_pc  = 1'b0;
        rd_mem  = 1'b0;
        latch_i = 1'b0;
        inc_sc  = 1'b0;
        clr_sc  = 1'b0;
        if (run && !rst) begin
            unique case (state_q)
                PH_FETCH_ADDR: begin
                    bus_sel = BUS_PC;
                    ld_ar   = 1'b1;
                    inc_sc  = 1'b1;
                end
                PH_FETCH_WORD: begin
                    bus_sel = BUS_MEM;
                    rd_mem  = 1'b1;
                    ld_ir   = 1'b1;
                    inc_pc  = 1'b1;
                    inc_sc  = 1'b1;
                end
                PH_DECODE: begin
                    bus_sel = BUS_IR;
                    ld_ar   = 1'b1;
                    latch_i = 1'b1;
                    inc_sc  = 1'b1;
                end
                PH_RESOLVE: begin
                    clr_sc = 1'b1;
                    if (is_memref && ind_mode) begin
                        bus_sel = BUS_MEM;
                        rd_mem  = 1'b1;
                        ld_ar   = 1'b1;
                    end
                end
            endcase
        end
    end

    assign phase = state_q;

    // R9: after the clear strobe the sequence restarts at the first step.
    assert_restart_after_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr_sc |=> (state_q == PH_FETCH_ADDR));

endmodule

// File: rtl/fetch_sequencer.sv
`timescale 1ns/1ps
module fetch_sequencer
    import sqc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int SC_W   = 4,
    parameter int OPC_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  load_we,
    input  logic [ADDR_W-1:0]     load_addr,
    input  logic [DATA_W-1:0]     load_data,
    output logic [ADDR_W-1:0]     pc,
    output logic [ADDR_W-1:0]     ar,
    output logic [DATA_W-1:0]     ir,
    output logic                  ind_mode,
    output logic [SC_W-1:0]       sc,
    output logic [(1<<SC_W)-1:0]  tstep,
    output logic [(1<<OPC_W)-1:0] opdec,
    output logic                  is_memref,
    output logic                  is_regref,
    output logic                  is_io,
    output logic [2:0]            bus_sel,
    output logic                  ld_ar,
    output logic                  ld_ir,
    output logic                  inc_pc,
    output logic                  rd_mem,
    output logic                  latch_i,
    output logic                  inc_sc,
    output logic                  clr_sc
);
    localparam int TSTEPS   = 1 << SC_W;
    localparam int OPCODES  = 1 << OPC_W;
    localparam int OPC_LSB  = ADDR_W;
    localparam int MODE_BIT = DATA_W - 1;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    bus_src_e          bus_src;
    phase_e            phase;
    logic [DATA_W-1:0] mem_q;
    logic [OPC_W-1:0]  opcode;
    logic              non_mem;

    sqc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .is_memref (is_memref),
        .ind_mode  (ind_mode),
        .phase     (phase),
        .bus_sel   (bus_src),
        .ld_ar     (ld_ar),
        .ld_ir     (ld_ir),
        .inc_pc    (inc_pc),
        .rd_mem    (rd_mem),
        .latch_i   (latch_i),
        .inc_sc    (inc_sc),
        .clr_sc    (clr_sc)
    );

    sqc_seq_counter #(.W(SC_W)) u_sc (
        .clk   (clk),
        .rst   (rst),
        .inc   (inc_sc),
        .clr   (clr_sc),
        .count (sc)
    );

    sqc_decoder #(.IN_W(SC_W)) u_tdec (
        .code (sc),
        .hot  (tstep)
    );

    sqc_word_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .we    (load_we),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (ar),
        .rdata (mem_q)
    );

    sqc_datapath #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_src),
        .mem_q    (mem_q),
        .ld_ar    (ld_ar),
        .ld_ir    (ld_ir),
        .inc_pc   (inc_pc),
        .latch_i  (latch_i),
        .pc       (pc),
        .ar       (ar),
        .ir       (ir),
        .ind_mode (ind_mode)
    );

    assign opcode = ir[OPC_LSB +: OPC_W];

    sqc_decoder #(.IN_W(OPC_W)) u_odec (
        .code (opcode),
        .hot  (opdec)
    );

    // All-ones opcode separates register and I/O words from memory-reference.
    assign non_mem   = opdec[OPCODES-1];
    assign is_memref = !non_mem;
    assign is_regref = non_mem && !ir[MODE_BIT];
    assign is_io     = non_mem && ir[MODE_BIT];
    assign bus_sel   = bus_src;

    // R1: reset brings the registers back to zero.
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pc == '0 && sc == '0 && ar == '0 && ir == '0 && !ind_mode));

    // R2: first step moves PC into AR.
    assert_t0_pc_to_ar_R2: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(0) && run) |=> (ar == $past(pc) && sc == SC_W'(1)));

    // R3: second step loads the addressed word and advances PC.
    assert_t1_fetch_word_R3: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(1) && run) |=> (ir == $past(mem_q) && pc == $past(pc) + ONE));

    // R4: third step takes the address field and the mode bit.
    assert_t2_decode_R4: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(2) && run) |=>
            (ar == $past(ir[ADDR_W-1:0]) && ind_mode == $past(ir[MODE_BIT])));

    // R5: exactly one class flag.
    assert_one_class_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot({is_memref, is_regref, is_io}));

    // R6: counter and phase state agree; timing step is one-hot at SC.
    assert_sc_tracks_phase_R6: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(phase) && tstep == (TSTEPS'(1) << sc)));

    // R7: indirect memory-reference replaces AR with the pointer word.
    assert_indirect_read_R7: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(3) && run && is_memref && ind_mode) |=>
            (ar == $past(mem_q[ADDR_W-1:0])));

    // R8: any other word leaves AR alone in the last step.
    assert_no_addr_change_R8: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(3) && run && !(is_memref && ind_mode)) |=> $stable(ar));

    // R9: last step returns SC to zero with PC untouched.
    assert_sc_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        (sc == SC_W'(3) && run) |=> (sc == '0 && $stable(pc)));

    // R10: nothing moves while run is low.
    assert_stall_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(sc) && $stable(pc) && $stable(ar) && $stable(ir)
                  && $stable(ind_mode)));

endmodule

// File: tb/sim_fetch_sequencer.sv
`timescale 1ns/1ps
module sim_fetch_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        load_we = 1'b0;
    logic [11:0] load_addr = '0;
    logic [15:0] load_data = '0;

    logic [11:0] pc, ar;
    logic [15:0] ir;
    logic        ind_mode;
    logic [3:0]  sc;
    logic [15:0] tstep;
    logic [7:0]  opdec;
    logic        is_memref, is_regref, is_io;
    logic [2:0]  bus_sel;
    logic        ld_ar, ld_ir, inc_pc, rd_mem, latch_i, inc_sc, clr_sc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Strobe vector: {ld_ar, ld_ir, inc_pc, rd_mem, latch_i, inc_sc, clr_sc}
    wire [6:0] strb = {ld_ar, ld_ir, inc_pc, rd_mem, latch_i, inc_sc, clr_sc};

    always #5 clk = ~clk;

    fetch_sequencer u0 (
        .clk(clk), .rst(rst), .run(run),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
        .pc(pc), .ar(ar), .ir(ir), .ind_mode(ind_mode), .sc(sc),
        .tstep(tstep), .opdec(opdec),
        .is_memref(is_memref), .is_regref(is_regref), .is_io(is_io),
        .bus_sel(bus_sel), .ld_ar(ld_ar), .ld_ir(ld_ir), .inc_pc(inc_pc),
        .rd_mem(rd_mem), .latch_i(latch_i), .inc_sc(inc_sc), .clr_sc(clr_sc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic put_word(input logic [11:0] a, input logic [15:0] d);
        load_we = 1'b1; load_addr = a; load_data = d;
        tick();
        load_we = 1'b0;
    endtask

    task automatic do_reset();
        run = 1'b0; rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R1", "pc", pc, 12'h000);
        chk("R1", "sc", sc, 4'h0);
        chk("R1", "ar/ir", {ar, ir}, 28'h0);
        chk("R1", "mode", ind_mode, 1'b0);
        chk("R1", "strobes idle", {bus_sel, strb}, 10'h0);
        chk("R6", "tstep at T0", tstep, 16'h0001);
    endtask

    task automatic t_direct_fetch();
        run = 1'b1; #1;
        chk("R2", "T0 bus/strobes", {bus_sel, strb}, {3'd2, 7'b1000010});
        tick();
        chk("R2", "AR<-PC", ar, 12'h000);
        chk("R6", "tstep at T1", tstep, 16'h0002);
        chk("R3", "T1 bus/strobes", {bus_sel, strb}, {3'd7, 7'b0111010});
        tick();
        chk("R3", "IR<-mem", ir, 16'h1234);
        chk("R11", "loaded word fetched", ir, 16'h1234);
        chk("R3", "PC+1", pc, 12'h001);
        chk("R4", "T2 bus/strobes", {bus_sel, strb}, {3'd5, 7'b1000110});
        chk("R5", "class memref", {is_memref, is_regref, is_io}, 3'b100);
        chk("R6", "opdec op1", opdec, 8'h02);
        tick();
        chk("R4", "AR<-IR field", ar, 12'h234);
        chk("R4", "mode latched 0", ind_mode, 1'b0);
        chk("R8", "T3 direct strobes", {bus_sel, strb}, {3'd0, 7'b0000001});
        tick();
        chk("R8", "AR kept", ar, 12'h234);
        chk("R9", "SC cleared", sc, 4'h0);
        chk("R9", "PC kept", pc, 12'h001);
    endtask

    task automatic t_indirect_fetch();
        tick(); tick(); tick();
        chk("R4", "AR<-pointer addr", ar, 12'h050);
        chk("R4", "mode latched 1", ind_mode, 1'b1);
        chk("R6", "opdec op2", opdec, 8'h04);
        chk("R7", "T3 indirect strobes", {bus_sel, strb}, {3'd7, 7'b1001001});
        tick();
        chk("R7", "AR<-M[AR]", ar, 12'hABC);
        chk("R9", "SC cleared", sc, 4'h0);
        chk("R9", "PC next", pc, 12'h002);
    endtask

    task automatic t_register_ref();
        tick(); tick(); tick();
        chk("R5", "class regref", {is_memref, is_regref, is_io}, 3'b010);
        chk("R6", "opdec op7", opdec, 8'h80);
        chk("R8", "T3 regref strobes", {bus_sel, strb}, {3'd0, 7'b0000001});
        tick();
        chk("R8", "AR regref kept", ar, 12'h800);
    endtask

    task automatic t_io_with_mode_set();
        tick(); tick(); tick();
        chk("R5", "class io", {is_memref, is_regref, is_io}, 3'b001);
        chk("R4", "io mode 1", ind_mode, 1'b1);
        chk("R8", "T3 io no indirect", {bus_sel, strb}, {3'd0, 7'b0000001});
        tick();
        chk("R8", "AR io kept", ar, 12'h400);
        chk("R9", "PC after io", pc, 12'h004);
    endtask

    task automatic t_stall_mid_instruction();
        tick(); tick();
        chk("R10", "reached T2", sc, 4'h2);
        run = 1'b0; #1;
        chk("R10", "stalled strobes", {bus_sel, strb}, 10'h0);
        tick(); tick(); tick();
        chk("R10", "SC held", sc, 4'h2);
        chk("R10", "PC held", pc, 12'h005);
        chk("R10", "IR held", ir, 16'h3123);
        chk("R10", "AR held", ar, 12'h004);
        run = 1'b1;
        tick();
        chk("R10", "resumed T2 transfer", ar, 12'h123);
        chk("R10", "resumed to T3", sc, 4'h3);
        tick();
        chk("R9", "SC cleared after resume", sc, 4'h0);
    endtask

    task automatic t_pc_wrap();
        do_reset();
        run = 1'b1;
        repeat (4095 * 4) tick();
        chk("R12", "PC at top", pc, 12'hFFF);
        chk("R12", "SC at T0", sc, 4'h0);
        tick(); tick();
        chk("R12", "PC wrapped", pc, 12'h000);
        chk("R12", "top word fetched", ir, 16'h7000);
        run = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        tick();
        for (int a = 0; a < 4096; a++) put_word(12'(a), 16'h7000);
        put_word(12'h000, 16'h1234);  // direct, opcode 1
        put_word(12'h001, 16'hA050);  // indirect, opcode 2
        put_word(12'h050, 16'h0ABC);  // pointer word
        put_word(12'h002, 16'h7800);  // register-reference
        put_word(12'h003, 16'hF400);  // input-output, mode bit set
        put_word(12'h004, 16'h3123);  // direct, opcode 3
        t_reset_state();
        t_direct_fetch();
        t_indirect_fetch();
        t_register_ref();
        t_io_with_mode_set();
        t_stall_mid_instruction();
        t_pc_wrap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule